// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This block is the combinational result-and-flag stage for the rotate, shift and single-bit instructions of an 8-bit accumulator processor. An external datapath supplies a register value, the current flag vector, a 4-bit operation code, a bit index and a fast-form select. In the same cycle the unit returns the new register value and the new flag vector. Operand fetch, memory access, decoding and cycle timing are handled by the surrounding datapath.

The unit provides eight rotate and shift forms. These are circular rotates, rotates through carry, a left shift that fills with zero, a left shift that fills with one, a sign-keeping right shift and a zero-filling right shift. It also provides a non-destructive bit test and bit clear/set. The fast accumulator form of the four rotates changes only carry, half-carry and subtract. The data width is a parameter, and the bit index width is derived from it.

Flag vector layout, used on both `flags_i` and `flags_o`: bit 5 sign, bit 4 zero, bit 3 half-carry, bit 2 parity/overflow, bit 1 subtract, bit 0 carry.

Top module: `rsb_unit`

## Requirements
- R1: For every rotate or shift (op 0 to 7), carry (flag bit 0) takes the bit shifted out. That is the old MSB for the left forms (op 0, 2, 4, 6) and the old bit 0 for the right forms (op 1, 3, 5, 7).
- R2: Op 0 rotates left circularly, so the old MSB also enters bit 0. Op 1 rotates right circularly, so the old bit 0 also enters the MSB.
- R3: Op 2 rotates left and op 3 rotates right through carry. The incoming carry (flags_i bit 0) fills the vacated end.
- R4: Op 4 shifts left and fills bit 0 with 0. Op 6 shifts left and fills bit 0 with 1. Op 5 shifts right and keeps the MSB unchanged. Op 7 shifts right and fills the MSB with 0.
- R5: In the general form of op 0 to 7, sign equals the result MSB and zero is set for a zero result. Half-carry and subtract are cleared. Parity is set when the result holds an even number of ones.
- R6: With fast_i high and op 0 to 3, the result and carry match the general form. Half-carry and subtract are cleared, and sign, zero and parity are copied from flags_i.
- R7: fast_i has no effect on the result or flags for op 4 to 15.
- R8: Op 8 tests the bit selected by bit_sel_i and returns the operand unchanged. Zero and parity are set when the bit is 0. Sign is set only when the MSB is tested and found 1. Half-carry is set, subtract is cleared and carry is unchanged.
- R9: Op 9 forces the selected bit to 0 and op 10 forces it to 1. All other bits and all flags pass through unchanged.
- R10: Op 11 to 15 return the operand and flags_i unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | DATA_W | Register value to operate on |
| flags_i | input | 6 | Current flags (layout above), bit 0 is the incoming carry |
| op_i | input | 4 | Operation code (0 to 10 defined) |
| bit_sel_i | input | $clog2(DATA_W) | Bit index for op 8 to 10 |
| fast_i | input | 1 | Selects the accumulator-only rotate form for op 0 to 3 |
| result_o | output | DATA_W | New register value |
| flags_o | output | 6 | New flag vector |

## Verification
The bench builds the unit at the default DATA_W of 8. At this width every operand value and every bit index can be reached by a few thousand seeded random vectors. It also makes directed cases cheap: MSB into carry, the all-zero result that sets zero and parity, and sign extension of a negative value. Random vectors cover all sixteen operation codes, including the undefined ones, with fast_i toggled freely. This shows that the fast select matters only for the four rotates.

// File: rtl/rsb_pkg.sv
// Package: shared operation codes, flag positions and flag-update classes
// for the rotate/shift/bit unit. Assumes a 6-bit flag vector.
package rsb_pkg;

    localparam int FLAG_W = 6;
    localparam int FLG_C  = 0;
    localparam int FLG_N  = 1;
    localparam int FLG_P  = 2;
    localparam int FLG_H  = 3;
    localparam int FLG_Z  = 4;
    localparam int FLG_S  = 5;

    typedef enum logic [3:0] {
        OP_ROTL   = 4'd0,
        OP_ROTR   = 4'd1,
        OP_ROTLC  = 4'd2,
        OP_ROTRC  = 4'd3,
        OP_SHL0   = 4'd4,
        OP_SHRA   = 4'd5,
        OP_SHL1   = 4'd6,
        OP_SHRL   = 4'd7,
        OP_BTEST  = 4'd8,
        OP_BCLR   = 4'd9,
        OP_BSET   = 4'd10
    } rsb_op_e;

    typedef enum logic [1:0] {
        CLS_GENERAL = 2'd0,
        CLS_FAST    = 2'd1,
        CLS_TEST    = 2'd2,
        CLS_KEEP    = 2'd3
    } rsb_cls_e;

    typedef enum logic [1:0] {
        BM_PASS = 2'd0,
        BM_CLR  = 2'd1,
        BM_SET  = 2'd2
    } rsb_bmode_e;

endpackage

// File: rtl/rsb_shifter.sv
// Module: rsb_shifter
// Computes the eight rotate/shift forms selected by sel_i and the bit that
// leaves the word. Assumes DATA_W >= 2. Purely combinational.
module rsb_shifter #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              carry_i,
    input  logic [2:0]        sel_i,
    output logic [DATA_W-1:0] data_o,
    output logic              out_bit_o
);

    localparam int MSB = DATA_W - 1;

    logic left_dir;
    logic fill_bit;

    // Purpose: direction is the low select bit (even codes shift left).
    always_comb left_dir = ~sel_i[0];

    // Purpose: pick the bit that enters the vacated end for each form.
    always_comb begin
        unique case (sel_i)
            3'd0:    fill_bit = data_i[MSB];
            3'd1:    fill_bit = data_i[0];
            3'd2:    fill_bit = carry_i;
            3'd3:    fill_bit = carry_i;
            3'd4:    fill_bit = 1'b0;
            3'd5:    fill_bit = data_i[MSB];
            3'd6:    fill_bit = 1'b1;
            default: fill_bit = 1'b0;
        endcase
    end

    // Purpose: form the shifted word and the bit shifted out.
    always_comb begin
        if (left_dir) begin
            data_o    = {data_i[MSB-1:0], fill_bit};
            out_bit_o = data_i[MSB];
        end else begin
            data_o    = {fill_bit, data_i[MSB:1]};
            out_bit_o = data_i[0];
        end
    end

endmodule

// File: rtl/rsb_bitop.sv
// Module: rsb_bitop
// Builds a one-hot mask from the bit index, reports the selected bit and
// applies clear/set. Assumes DATA_W is a power of two.
module rsb_bitop #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  rsb_pkg::rsb_bmode_e mode_i,
    output logic [DATA_W-1:0] data_o,
    output logic              sel_bit_o
);

    import rsb_pkg::*;

    logic [DATA_W-1:0] mask;

    // One decoder slice per bit position.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (idx_i == IDX_W'(g));
    end

    // Purpose: extract the selected bit.
    always_comb sel_bit_o = |(data_i & mask);

    // Purpose: apply the clear or set to the selected bit.
    always_comb begin
        unique case (mode_i)
            BM_CLR:  data_o = data_i & ~mask;
            BM_SET:  data_o = data_i | mask;
            default: data_o = data_i;
        endcase
    end

endmodule

// File: rtl/rsb_flags.sv
// Module: rsb_flags
// Produces the outgoing flag vector for one of four update classes.
// Assumes the flag layout defined in rsb_pkg.
module rsb_flags #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  rsb_pkg::rsb_cls_e             cls_i,
    input  logic [DATA_W-1:0]             result_i,
    input  logic [rsb_pkg::FLAG_W-1:0]    flags_i,
    input  logic                          carry_new_i,
    input  logic                          tested_bit_i,
    input  logic [IDX_W-1:0]              idx_i,
    output logic [rsb_pkg::FLAG_W-1:0]    flags_o
);

    import rsb_pkg::*;

    logic res_zero;
    logic res_even;
    logic msb_tested;

    // Purpose: result-derived zero and even-parity terms.
    always_comb begin
        res_zero = (result_i == '0);
        res_even = ~(^result_i);
    end

    // Purpose: flag that the bit test looks at the most significant bit.
    always_comb msb_tested = (idx_i == IDX_W'(DATA_W - 1));

    // Purpose: assemble the flag vector for the selected class.
    always_comb begin
        flags_o = flags_i;
        unique case (cls_i)
            CLS_GENERAL: begin
                flags_o[FLG_S] = result_i[DATA_W-1];
                flags_o[FLG_Z] = res_zero;
                flags_o[FLG_H] = 1'b0;
                flags_o[FLG_P] = res_even;
                flags_o[FLG_N] = 1'b0;
                flags_o[FLG_C] = carry_new_i;
            end
            CLS_FAST: begin
                flags_o[FLG_H] = 1'b0;
                flags_o[FLG_N] = 1'b0;
                flags_o[FLG_C] = carry_new_i;
            end
            CLS_TEST: begin
                flags_o[FLG_S] = tested_bit_i & msb_tested;
                flags_o[FLG_Z] = ~tested_bit_i;
                flags_o[FLG_H] = 1'b1;
                flags_o[FLG_P] = ~tested_bit_i;
                flags_o[FLG_N] = 1'b0;
            end
            default: flags_o = flags_i;
        endcase
    end

endmodule

// File: rtl/rsb_unit.sv
// Module: rsb_unit (top)
// Rotate, shift and single-bit unit: classifies the operation, routes the
// operand through the shifter or the bit logic and builds the flags.
// Assumes an external datapath registers the outputs; no state inside.
module rsb_unit #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [5:0]        flags_i,
    input  logic [3:0]        op_i,
    input  logic [IDX_W-1:0]  bit_sel_i,
    input  logic              fast_i,
    output logic [DATA_W-1:0] result_o,
    output logic [5:0]        flags_o
);

    import rsb_pkg::*;

    localparam int MSB = DATA_W - 1;

    rsb_op_e    op_e;
    rsb_cls_e   cls;
    rsb_bmode_e bmode;
    logic       is_shift;
    logic       is_bitop;
    logic [DATA_W-1:0] shift_res;
    logic [DATA_W-1:0] bit_res;
    logic       shift_out;
    logic       tested;

    // Purpose: view the raw code as the operation enum.
    always_comb op_e = rsb_op_e'(op_i);

    // Purpose: split codes into rotate/shift and bit-operation groups.
    always_comb begin
        is_shift = (op_i[3] == 1'b0);
        is_bitop = (op_e == OP_BTEST) || (op_e == OP_BCLR) || (op_e == OP_BSET);
    end

    // Purpose: choose the flag-update class.
    always_comb begin
        if (is_shift)
            cls = (fast_i && (op_i[2] == 1'b0)) ? CLS_FAST : CLS_GENERAL;
        else if (op_e == OP_BTEST)
            cls = CLS_TEST;
        else
            cls = CLS_KEEP;
    end

    // Purpose: choose the bit-logic mode.
    always_comb begin
        if (op_e == OP_BCLR)      bmode = BM_CLR;
        else if (op_e == OP_BSET) bmode = BM_SET;
        else                      bmode = BM_PASS;
    end

    rsb_shifter #(.DATA_W(DATA_W)) i_shifter (
        .data_i    (operand_i),
        .carry_i   (flags_i[FLG_C]),
        .sel_i     (op_i[2:0]),
        .data_o    (shift_res),
        .out_bit_o (shift_out)
    );

    rsb_bitop #(.DATA_W(DATA_W)) i_bitop (
        .data_i    (operand_i),
        .idx_i     (bit_sel_i),
        .mode_i    (bmode),
        .data_o    (bit_res),
        .sel_bit_o (tested)
    );

    rsb_flags #(.DATA_W(DATA_W)) i_flags (
        .cls_i        (cls),
        .result_i     (result_o),
        .flags_i      (flags_i),
        .carry_new_i  (shift_out),
        .tested_bit_i (tested),
        .idx_i        (bit_sel_i),
        .flags_o      (flags_o)
    );

    // Purpose: select the result word from the active group.
    always_comb begin
        if (is_shift)      result_o = shift_res;
        else if (is_bitop) result_o = bit_res;
        else               result_o = operand_i;
    end

    // Purpose: check the assembled outputs against the operation rules.
    always_comb begin
        if (is_shift && (op_i[0] == 1'b0)) begin
            a_r1_carry_left: assert (flags_o[FLG_C] == operand_i[MSB])
                else $error("R1 left carry mismatch");
        end
        if (is_shift && (op_i[0] == 1'b1)) begin
            a_r1_carry_right: assert (flags_o[FLG_C] == operand_i[0])
                else $error("R1 right carry mismatch");
        end
        if (op_e == OP_SHRA) begin
            a_r4_sign_kept: assert (result_o[MSB] == operand_i[MSB])
                else $error("R4 sign not preserved");
        end
        if (is_shift && fast_i && (op_i[2] == 1'b0)) begin
            a_r6_fast_keeps: assert ((flags_o[FLG_S] == flags_i[FLG_S]) &&
                                     (flags_o[FLG_Z] == flags_i[FLG_Z]) &&
                                     (flags_o[FLG_P] == flags_i[FLG_P]))
                else $error("R6 fast rotate touched S/Z/P");
        end
        if (op_e == OP_BTEST) begin
            a_r8_test_nondestructive: assert ((result_o == operand_i) &&
                                              (flags_o[FLG_Z] == ~operand_i[bit_sel_i]) &&
                                              (flags_o[FLG_C] == flags_i[FLG_C]))
                else $error("R8 bit test mismatch");
        end
        if ((op_e == OP_BCLR) || (op_e == OP_BSET)) begin
            a_r9_flags_kept: assert (flags_o == flags_i)
                else $error("R9 clear/set changed flags");
        end
        if (op_i > 4'd10) begin
            a_r10_passthru: assert ((result_o == operand_i) && (flags_o == flags_i))
                else $error("R10 undefined code altered state");
        end
    end

endmodule

// File: tb/test_rsb_unit.sv
// Bench for rsb_unit: directed corner cases plus seeded random vectors,
// compared against an independent reference function.
module test_rsb_unit;

    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] operand_i = '0;
    logic [5:0] flags_i = '0;
    logic [3:0] op_i = 4'd15;
    logic [2:0] bit_sel_i = '0;
    logic       fast_i = 1'b0;
    logic [7:0] result_o;
    logic [5:0] flags_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rsb_unit #(.DATA_W(W)) i_rsb_unit (
        .operand_i (operand_i),
        .flags_i   (flags_i),
        .op_i      (op_i),
        .bit_sel_i (bit_sel_i),
        .fast_i    (fast_i),
        .result_o  (result_o),
        .flags_o   (flags_o)
    );

    // Reference: {result[7:0], flags[5:0]} with flags S Z H P N C.
    function automatic logic [13:0] ref_model(input logic [7:0] a, input logic [5:0] f,
                                              input logic [3:0] op, input logic [2:0] idx,
                                              input logic fast);
        logic [7:0] r;
        logic [5:0] fo;
        logic c;
        logic b;
        r = a; fo = f; c = f[0];
        if (op < 4'd8) begin
            case (op)
                4'd0: begin r = {a[6:0], a[7]}; c = a[7]; end
                4'd1: begin r = {a[0], a[7:1]}; c = a[0]; end
                4'd2: begin r = {a[6:0], f[0]}; c = a[7]; end
                4'd3: begin r = {f[0], a[7:1]}; c = a[0]; end
                4'd4: begin r = {a[6:0], 1'b0}; c = a[7]; end
                4'd5: begin r = {a[7], a[7:1]}; c = a[0]; end
                4'd6: begin r = {a[6:0], 1'b1}; c = a[7]; end
                default: begin r = {1'b0, a[7:1]}; c = a[0]; end
            endcase
            if (fast && op < 4'd4)
                fo = {f[5], f[4], 1'b0, f[2], 1'b0, c};
            else
                fo = {r[7], (r == 8'h00), 1'b0, ~(^r), 1'b0, c};
        end else if (op == 4'd8) begin
            b = a[idx];
            fo = {b & (idx == 3'd7), ~b, 1'b1, ~b, 1'b0, f[0]};
        end else if (op == 4'd9) begin
            r[idx] = 1'b0;
        end else if (op == 4'd10) begin
            r[idx] = 1'b1;
        end
        return {r, fo};
    endfunction

    function automatic string res_req(input logic [3:0] op, input logic fast);
        if (op < 4'd4 && fast) return "R6";
        if (op >= 4'd4 && fast) return "R7";
        if (op < 4'd2) return "R2";
        if (op < 4'd4) return "R3";
        if (op < 4'd8) return "R4";
        if (op == 4'd8) return "R8";
        if (op < 4'd11) return "R9";
        return "R10";
    endfunction

    function automatic string flag_req(input logic [3:0] op, input logic fast);
        if (op < 4'd4 && fast) return "R6";
        if (op >= 4'd4 && fast) return "R7";
        if (op < 4'd8) return "R5";
        if (op == 4'd8) return "R8";
        if (op < 4'd11) return "R9";
        return "R10";
    endfunction

    // Drive one vector at the falling edge, sample 1 ns later.
    task automatic apply(input logic [7:0] a, input logic [5:0] f, input logic [3:0] op,
                         input logic [2:0] idx, input logic fast);
        logic [13:0] exp;
        @(negedge clk);
        operand_i = a; flags_i = f; op_i = op; bit_sel_i = idx; fast_i = fast;
        #1;
        exp = ref_model(a, f, op, idx, fast);
        checks++;
        if (result_o !== exp[13:6]) begin
            errors++;
            $display("FAIL %s result op=%0d a=%h: actual=%h expected=%h",
                     res_req(op, fast), op, a, result_o, exp[13:6]);
        end
        checks++;
        if (flags_o[5:1] !== exp[5:1]) begin
            errors++;
            $display("FAIL %s flags op=%0d a=%h: actual=%b expected=%b",
                     flag_req(op, fast), op, a, flags_o[5:1], exp[5:1]);
        end
        checks++;
        if (flags_o[0] !== exp[0]) begin
            errors++;
            $display("FAIL %s carry op=%0d a=%h: actual=%b expected=%b",
                     (op < 4'd8) ? "R1" : flag_req(op, fast), op, a, flags_o[0], exp[0]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 100000) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: undefined code passes everything through (R10).
        apply(8'h00, 6'b000000, 4'd15, 3'd0, 1'b0);
        apply(8'hA5, 6'b101101, 4'd11, 3'd3, 1'b1);

        // R2: circular rotates move the end bit round and into carry.
        apply(8'h80, 6'b000000, 4'd0, 3'd0, 1'b0);   // -> 01, C=1
        apply(8'h01, 6'b000000, 4'd1, 3'd0, 1'b0);   // -> 80, C=1, S=1
        // R3: through-carry forms.
        apply(8'h80, 6'b000000, 4'd2, 3'd0, 1'b0);   // -> 00, Z=1, P=1, C=1
        apply(8'h00, 6'b000001, 4'd3, 3'd0, 1'b0);   // -> 80, C=0
        // R4: fills and sign keep.
        apply(8'hFF, 6'b000000, 4'd4, 3'd0, 1'b0);   // -> FE
        apply(8'h81, 6'b000000, 4'd5, 3'd0, 1'b0);   // -> C0, C=1
        apply(8'h00, 6'b000000, 4'd6, 3'd0, 1'b0);   // -> 01
        apply(8'h01, 6'b000000, 4'd7, 3'd0, 1'b0);   // -> 00, Z=1, C=1
        // R6: fast form keeps S/Z/P even when result would change them.
        apply(8'h80, 6'b111110, 4'd2, 3'd0, 1'b1);
        apply(8'h01, 6'b000000, 4'd1, 3'd0, 1'b1);
        // R7: fast select ignored outside the rotates.
        apply(8'h01, 6'b110100, 4'd7, 3'd0, 1'b1);
        apply(8'h7F, 6'b000001, 4'd8, 3'd7, 1'b1);
        // R8: bit test.
        apply(8'h80, 6'b000001, 4'd8, 3'd7, 1'b0);   // S=1, Z=0, C kept
        apply(8'h7F, 6'b000000, 4'd8, 3'd7, 1'b0);   // Z=1, P=1
        // R9: clear and set leave flags alone.
        apply(8'hFF, 6'b010101, 4'd9, 3'd4, 1'b0);
        apply(8'h00, 6'b101010, 4'd10, 3'd0, 1'b0);

        // Random sweep across every code and operand.
        for (int i = 0; i < 3000; i++) begin
            apply(8'($urandom), 6'($urandom), 4'($urandom), 3'($urandom), 1'($urandom));
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule